// File: doc/BRIEF.md
# Shared-Address GPIO Port with Role-Selected Read-Back

This block is a 32-pin general-purpose I/O port attached to a small processor core. Two physical registers share one operand address: an input register that holds the synchronised pad levels, and an output latch. A direction register sits at a second address. On each access the core gives the operation code and the operand role. The role flag says whether the port address is the destination, and a second flag says whether the instruction writes its result back. The core also gives the other operand and a valid strobe. The block returns the read value in the same cycle and updates the addressed latch on the clock edge.

Which register is read depends on the role. As a source, or as a destination with no write-back (test or compare style), the shared address returns the input pins. As the destination of a read-modify-write, it returns the output latch and writes the result back to it. This means a read-modify-write never picks up a pin level that an outside circuit is overriding, and back-to-back updates build on each other correctly. The direction register follows the same atomic write rules.

Pad levels pass through a two-flop synchroniser on the way in. The output latch and the direction register each drive the pads through one register stage on the way out. A pin whose direction bit is 1 is driven with its latch bit. A pin whose direction bit is 0 is left floating. All 32 pins are mapped from reset with no setup needed.

Top module: `gpio_alias_port`

## Requirements
- R1: After synchronous reset, the output latch, the direction register, `pad_out` and `pad_oe` are all zero.
- R2: A source read of the shared address (`acc_dir`=0, `acc_is_dst`=0) returns `pad_in` as it was two clock edges earlier.
- R3: A write-back access with the shared address as destination (`acc_dir`=0, `acc_is_dst`=1, `acc_wb`=1) returns the output latch on `rd_data`. The operation result is stored in the output latch at the next edge.
- R4: Operation codes are 3'b000 MOV (result = src), 3'b001 AND (old & src), 3'b010 ANDN (old & ~src), 3'b011 OR (old | src) and 3'b100 XOR (old ^ src).
- R5: A destination access without write-back (`acc_wb`=0) returns the synchronised inputs and leaves both latches unchanged.
- R6: Read-modify-write accesses in consecutive cycles each see the previous cycle's result and give the cumulative value, whatever the pad levels are.
- R7: `pad_out` and `pad_oe` follow the output latch and the direction register one clock edge after the latch changes.
- R8: With `acc_dir`=1, the direction register is read in every role and is updated under the same write-back and operation rules as the output latch. `pad_oe` bit i = 1 means pin i is driven.
- R9: The input value always shows the pad level, even for a driven pin whose level is overridden from outside.
- R10: Codes 3'b101 to 3'b111 change neither latch.
- R11: While `acc_valid` is 0, neither latch changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Port access this cycle |
| acc_dir | input | 1 | 1 selects the direction register address, 0 the shared address |
| acc_is_dst | input | 1 | Port address is the destination operand |
| acc_wb | input | 1 | Instruction writes its result back |
| acc_op | input | 3 | Operation code |
| acc_src | input | 32 | Other operand value |
| rd_data | output | 32 | Read value for the current access |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Registered pad output levels |
| pad_oe | output | 32 | Registered pad drive enables |

## Verification
Two functions can meet in one cycle: a read-modify-write on the output latch, and a pad level that disagrees with the driven value. The bench holds `pad_in` at a pattern unrelated to the latch contents. It then runs a chain of read-modify-writes with no gap between them. Each returned old value and the final latch must match the bench's running model and never the pad pattern. Source reads made between those steps must return the pad pattern.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;

    typedef enum logic [2:0] {
        OP_MOV  = 3'b000,
        OP_AND  = 3'b001,
        OP_ANDN = 3'b010,
        OP_OR   = 3'b011,
        OP_XOR  = 3'b100
    } gpio_op_e;

    typedef enum logic [1:0] {
        RD_INPUTS,
        RD_OUTLATCH,
        RD_DIRREG
    } rd_sel_e;

    function automatic logic op_known(input logic [2:0] op);
        return (op <= 3'b100);
    endfunction

    function automatic logic [31:0] apply_op(input logic [2:0] op,
                                             input logic [31:0] old_v,
                                             input logic [31:0] src_v);
        logic [31:0] r;
        case (gpio_op_e'(op))
            OP_MOV:  r = src_v;
            OP_AND:  r = old_v & src_v;
            OP_ANDN: r = old_v & ~src_v;
            OP_OR:   r = old_v | src_v;
            OP_XOR:  r = old_v ^ src_v;
            default: r = old_v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] in_val
);
    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= pad_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[g] <= '0;
                    else     stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign in_val = stg[STAGES-1];
endmodule

// File: rtl/gpio_latch.sv
module gpio_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (upd) q <= d;
    end

    // R11 / R10: without an update strobe the latch holds
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(q));
endmodule

// File: rtl/gpio_pad_stage.sv
module gpio_pad_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_out,
    input  logic [W-1:0] d_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pad_out <= '0;
            pad_oe  <= '0;
        end else begin
            pad_out <= d_out;
            pad_oe  <= d_oe;
        end
    end

    a_r7_pad_delay: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pad_out == $past(d_out)) && (pad_oe == $past(d_oe)));
endmodule

// File: rtl/gpio_alias_port.sv
module gpio_alias_port
    import gpio_alias_pkg::*;
#(
    parameter int W           = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         acc_valid,
    input  logic         acc_dir,
    input  logic         acc_is_dst,
    input  logic         acc_wb,
    input  logic [2:0]   acc_op,
    input  logic [W-1:0] acc_src,
    output logic [W-1:0] rd_data,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    logic [W-1:0] in_val, out_q, dir_q, old_v, new_v;
    rd_sel_e      rd_sel;
    logic         port_wr, upd_out, upd_dir;

    gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pad_in(pad_in), .in_val(in_val));

    always_comb begin
        if (acc_dir)                   rd_sel = RD_DIRREG;
        else if (acc_is_dst && acc_wb) rd_sel = RD_OUTLATCH;
        else                           rd_sel = RD_INPUTS;
    end

    always_comb begin
        case (rd_sel)
            RD_DIRREG:   old_v = dir_q;
            RD_OUTLATCH: old_v = out_q;
            default:     old_v = in_val;
        endcase
    end

    assign rd_data = old_v;
    assign new_v   = W'(apply_op(acc_op, 32'(old_v), 32'(acc_src)));
    assign port_wr = acc_valid && acc_is_dst && acc_wb && op_known(acc_op);
    assign upd_out = port_wr && !acc_dir;
    assign upd_dir = port_wr && acc_dir;

    gpio_latch #(.W(W)) u_out (
        .clk(clk), .rst(rst), .upd(upd_out), .d(new_v), .q(out_q));

    gpio_latch #(.W(W)) u_dir (
        .clk(clk), .rst(rst), .upd(upd_dir), .d(new_v), .q(dir_q));

    gpio_pad_stage #(.W(W)) u_pad (
        .clk(clk), .rst(rst), .d_out(out_q), .d_oe(dir_q),
        .pad_out(pad_out), .pad_oe(pad_oe));

    a_r4_mov_out: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_dir && acc_is_dst && acc_wb && acc_op == 3'b000)
        |=> out_q == $past(acc_src));

    a_r6_xor_cumul: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_dir && acc_is_dst && acc_wb && acc_op == 3'b100)
        |=> out_q == ($past(out_q) ^ $past(acc_src)));

    a_r10_bad_op: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_op > 3'b100) |=> ($stable(out_q) && $stable(dir_q)));

    a_r5_no_wb: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_wb) |=> ($stable(out_q) && $stable(dir_q)));
endmodule

// File: tb/sim_gpio_alias_port.sv
module sim_gpio_alias_port;
    logic        clk = 0, rst = 1;
    logic        acc_valid = 0, acc_dir = 0, acc_is_dst = 0, acc_wb = 0;
    logic [2:0]  acc_op = 0;
    logic [31:0] acc_src = 0, pad_in = 0;
    logic [31:0] rd_data, pad_out, pad_oe;
    int          errs = 0, checks = 0, cyc = 0;
    logic [31:0] rd, model;

    localparam logic [31:0] PADV = 32'hA5A5_5A5A;

    // {op, src, expected latch after}
    localparam logic [66:0] VEC [6] = '{
        {3'b000, 32'hF0F0_1234, 32'hF0F0_1234},
        {3'b001, 32'hFF00_FF00, 32'hF000_1200},
        {3'b011, 32'h0000_00FF, 32'hF000_12FF},
        {3'b010, 32'hF000_000F, 32'h0000_12F0},
        {3'b100, 32'hFFFF_0000, 32'hFFFF_12F0},
        {3'b100, 32'h0000_0007, 32'hFFFF_12F7}
    };

    always #2.5 clk = ~clk;

    gpio_alias_port u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_dir(acc_dir),
        .acc_is_dst(acc_is_dst), .acc_wb(acc_wb), .acc_op(acc_op),
        .acc_src(acc_src), .rd_data(rd_data), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe));

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // present one access at a negedge, sample rd_data, let one edge pass
    task automatic acc(input logic v, input logic d, input logic dst, input logic wb,
                       input logic [2:0] op, input logic [31:0] src);
        acc_valid = v; acc_dir = d; acc_is_dst = dst; acc_wb = wb;
        acc_op = op; acc_src = src;
        #1 rd = rd_data;
        @(negedge clk);
        acc_valid = 0; acc_wb = 0; acc_is_dst = 0; acc_dir = 0;
    endtask

    // read a latch without changing it: AND with all ones, written back
    task automatic peek(input logic d, output logic [31:0] v);
        acc(1, d, 1, 1, 3'b001, 32'hFFFF_FFFF);
        v = rd;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errs++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pad_out", pad_out, 32'h0);
        chk("R1 pad_oe", pad_oe, 32'h0);
        rst = 0;
        peek(0, v); chk("R1 out latch", v, 32'h0);
        peek(1, v); chk("R1 dir reg", v, 32'h0);

        // R2: two-edge input delay
        pad_in = PADV;
        acc(1, 0, 0, 0, 3'b000, 0); chk("R2 before edges", rd, 32'h0);
        acc(1, 0, 0, 0, 3'b000, 0); chk("R2 one edge", rd, 32'h0);
        acc(1, 0, 0, 0, 3'b000, 0); chk("R2 two edges", rd, PADV);

        // R3 R4 R6: back-to-back read-modify-write vector walk
        model = 32'h0;
        for (int i = 0; i < 6; i++) begin
            acc_valid = 1; acc_dir = 0; acc_is_dst = 1; acc_wb = 1;
            acc_op = VEC[i][66:64]; acc_src = VEC[i][63:32];
            #1 chk("R3 R6 old from latch", rd_data, model);
            @(negedge clk);
            model = VEC[i][31:0];
        end
        acc_valid = 0; acc_wb = 0; acc_is_dst = 0;
        peek(0, v); chk("R4 final latch", v, 32'hFFFF_12F7);

        // R9: overridden pins read the pad level
        acc(1, 0, 0, 0, 3'b000, 0); chk("R9 source read pads", rd, PADV);

        // R5: destination without write-back
        acc(1, 0, 1, 0, 3'b100, 32'hFFFF_FFFF); chk("R5 reads inputs", rd, PADV);
        peek(0, v); chk("R5 latch unchanged", v, 32'hFFFF_12F7);

        // R10: unknown codes
        acc(1, 0, 1, 1, 3'b101, 32'h0);
        acc(1, 1, 1, 1, 3'b111, 32'h1234);
        peek(0, v); chk("R10 out unchanged", v, 32'hFFFF_12F7);
        peek(1, v); chk("R10 dir unchanged", v, 32'h0);

        // R11: no valid strobe
        acc(0, 0, 1, 1, 3'b000, 32'h0);
        peek(0, v); chk("R11 out unchanged", v, 32'hFFFF_12F7);

        // R7: pad_out lags latch by one edge
        acc(1, 0, 1, 1, 3'b000, 32'h0000_0001);
        chk("R7 pad_out not yet", pad_out, 32'hFFFF_12F7);
        @(negedge clk);
        chk("R7 pad_out follows", pad_out, 32'h0000_0001);

        // R8: direction register
        acc(1, 1, 1, 1, 3'b000, 32'h0000_FFFF); chk("R8 old dir", rd, 32'h0);
        chk("R8 pad_oe not yet", pad_oe, 32'h0);
        @(negedge clk);
        chk("R8 pad_oe follows", pad_oe, 32'h0000_FFFF);
        acc(1, 1, 1, 1, 3'b100, 32'h00FF_00FF);
        acc(1, 1, 0, 0, 3'b000, 0); chk("R8 dir source read", rd, 32'h00FF_FF00);
        chk("R8 out untouched by dir", pad_out, 32'h0000_0001);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule